// File: doc/BRIEF.md
# Dashed Line Rasteriser

This block draws a straight line between two packed coordinate pairs into an 8-bit-per-pixel frame buffer. It steps along the longer axis one pixel at a time and uses an integer error term to decide when the shorter axis moves. Each pixel leaves on a write port as a linear address and a pair of bit masks. The memory applies them as `new = (old & keep) ^ flip`, so every supported raster operation, limited to the enabled bit planes, is carried out without reading the destination.

Software loads the endpoints, the colours, the raster operation and the plane mask through a small word-addressed register port. It then starts a drawing command by writing one of three command words. A solid line can move the start point onto the end point afterwards, so that polylines can be chained. Dashed lines are drawn as a sequence of segment commands along the same line. The first command draws the leading dash and remembers its length. Each later command skips everything already covered, draws its own run, and switches between the foreground and background colours for the next run.

Top module: `line_raster`

## Requirements
- R1: After reset `busy` and `px_valid` are low. The start and end points are (0,0), both colours are 0, the colour select is 0, the raster code is 3 and the plane mask is all ones.
- R2: Register words are selected by `cfg_addr`: 0 start point, 1 end point, 2 colours (foreground in bits 7:0, background in bits 23:16), 3 operation (colour select in bit 1, raster code in bits 11:8), 4 plane mask, 5 solid line command, 6 dash-start command, 7 dash-next command. A point is packed as x in bits 31:16 and y in bits 15:0.
- R3: A command is rejected if both endpoints have x >= FB_W or both have y >= FB_H. A rejected command writes no pixel, never raises `busy`, and leaves the start point unchanged.
- R4: Pixels follow the integer-error stepping rule in order of increasing major coordinate, one per step. The major axis is y when |dy| > |dx| and x otherwise. The minor coordinate moves by +1 or -1 (toward the end minor coordinate) when the error is positive. The error starts at 2·dmin − dmaj and gains 2·(dmin − dmaj) on a minor step and 2·dmin otherwise.
- R5: The address of a pixel is y·FB_W + x. A step whose x >= FB_W or y >= FB_H is counted but not written.
- R6: Each command latches its colour at issue: the foreground colour if the colour select is 1, the background colour if it is 0.
- R7: With plane mask m and colour c, the raster codes produce the following {keep, flip} pairs: 0 gives {~m, 0}; 3 gives {~m, c&m}; 6 gives {all ones, c&m}; 10 gives {all ones, m}; 15 gives {~m, m}. Any other code gives {all ones, 0}.
- R8: A dash-start command (length P in bits 31:16) draws at most P steps from the start, with at least one step. It stores P as the skip count.
- R9: A dash-next command (length L in bits 31:16) treats the first S steps as skipped, where S is the stored skip count, and stops after S+L steps. It then sets S to S+L and inverts the colour select. This happens even when the command is rejected.
- R10: A solid line command with bit 0 set copies the end point into the start point.
- R11: A pixel offered with `px_valid` keeps its address and masks until `px_ready`. `busy` is low in the cycle after the last pixel is accepted.
- R12: Any register or command write is ignored while `busy` is high, including a write in the same cycle as the acceptance of the final pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | A line is being drawn |
| px_valid | output | 1 | Pixel write offered |
| px_ready | input | 1 | Pixel write accepted |
| px_addr | output | AW | Linear pixel address y·FB_W + x |
| px_keep | output | PIX_W | Bits of the old pixel to keep |
| px_flip | output | PIX_W | Bits to invert after keeping |

## Verification
Two events can land in the same cycle: the handshake of the final pixel of a line, and a write on the register port. The bench holds `px_ready` high on a line of known length. It counts clock edges from the command so that a write to the operation register arrives exactly on the edge that accepts the last pixel. It then checks that `busy` is already low one cycle later, and that the following line still uses the old colour. This shows the write was dropped rather than applied. Randomised endpoints, raster codes, dash lengths and stalls on `px_ready` are compared pixel by pixel against a model of the stepping rule kept in the bench.

// File: rtl/lnd_pkg.sv
package lnd_pkg;
  localparam int CW = 16;        // coordinate field width
  localparam int LW = CW + 2;    // step / skip counter width

  typedef logic [CW-1:0] coord_t;

  typedef enum logic [2:0] {
    A_START = 3'd0, A_END = 3'd1, A_COLOR = 3'd2, A_OP = 3'd3,
    A_PMASK = 3'd4, A_LINE = 3'd5, A_DSTART = 3'd6, A_DNEXT = 3'd7
  } adr_e;

  typedef enum logic [3:0] {
    ROP_CLR = 4'd0, ROP_CPY = 4'd3, ROP_XOR = 4'd6, ROP_INV = 4'd10, ROP_SET = 4'd15
  } rop_e;

  typedef struct packed {
    coord_t        x0;
    coord_t        y0;
    coord_t        x1;
    coord_t        y1;
    logic          lim_en;
    logic [LW-1:0] skip;
    logic [LW-1:0] lim;
  } job_t;
endpackage

// File: rtl/lnd_regs.sv
module lnd_regs
  import lnd_pkg::*;
#(
  parameter int FB_W  = 1280,
  parameter int FB_H  = 1024,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             busy,
  output logic             go,
  output job_t             job,
  output logic [PIX_W-1:0] seg_col,
  output logic [PIX_W-1:0] pmask,
  output logic [3:0]       rop
);
  localparam logic [CW:0] WL = (CW+1)'(FB_W);
  localparam logic [CW:0] HL = (CW+1)'(FB_H);

  logic [31:0]      start_q, start_n, end_q, end_n;
  logic [PIX_W-1:0] fg_q, fg_n, bg_q, bg_n, pm_q, pm_n, col_q, col_n;
  logic             sel_q, sel_n;
  logic [3:0]       rop_q, rop_n;
  logic [LW-1:0]    skip_q, skip_n, len;
  logic             acc, reject;
  coord_t           sx, sy, ex, ey;

  always_comb begin
    sx     = start_q[31:16];
    sy     = start_q[15:0];
    ex     = end_q[31:16];
    ey     = end_q[15:0];
    reject = ({1'b0, sx} >= WL && {1'b0, ex} >= WL) ||
             ({1'b0, sy} >= HL && {1'b0, ey} >= HL);
    acc    = we && !busy;
    len    = {2'b00, wdata[31:16]};
    start_n = start_q; end_n = end_q; fg_n = fg_q; bg_n = bg_q;
    pm_n = pm_q; col_n = col_q; sel_n = sel_q; rop_n = rop_q; skip_n = skip_q;
    go  = 1'b0;
    job = '{x0: sx, y0: sy, x1: ex, y1: ey, lim_en: 1'b0, skip: '0, lim: len};
    if (acc) begin
      unique case (adr_e'(addr))
        A_START: start_n = wdata;
        A_END:   end_n   = wdata;
        A_COLOR: begin fg_n = wdata[PIX_W-1:0]; bg_n = wdata[16 +: PIX_W]; end
        A_OP:    begin sel_n = wdata[1]; rop_n = wdata[11:8]; end
        A_PMASK: pm_n = wdata[PIX_W-1:0];
        A_LINE: begin
          go    = !reject;
          col_n = sel_q ? fg_q : bg_q;
          if (wdata[0] && !reject) start_n = end_q;
        end
        A_DSTART: begin
          go         = !reject;
          col_n      = sel_q ? fg_q : bg_q;
          job.lim_en = 1'b1;
          skip_n     = len;
        end
        A_DNEXT: begin
          go         = !reject;
          col_n      = sel_q ? fg_q : bg_q;
          job.lim_en = 1'b1;
          job.skip   = skip_q;
          job.lim    = skip_q + len;
          skip_n     = skip_q + len;
          sel_n      = !sel_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0; end_q <= '0; fg_q <= '0; bg_q <= '0;
      pm_q <= '1; col_q <= '0; sel_q <= 1'b0; rop_q <= ROP_CPY; skip_q <= '0;
    end else begin
      start_q <= start_n; end_q <= end_n; fg_q <= fg_n; bg_q <= bg_n;
      pm_q <= pm_n; col_q <= col_n; sel_q <= sel_n; rop_q <= rop_n; skip_q <= skip_n;
    end
  end

  assign seg_col = col_q;
  assign pmask   = pm_q;
  assign rop     = rop_q;

  // R12: nothing that shapes a drawing changes while a line is in flight
  a_r12_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (we && busy) |=> ($stable(start_q) && $stable(sel_q) && $stable(skip_q) && $stable(rop_q)));
endmodule

// File: rtl/lnd_stepper.sv
module lnd_stepper
  import lnd_pkg::*;
#(
  parameter int FB_W = 1280,
  parameter int FB_H = 1024,
  localparam int AW  = $clog2(FB_W*FB_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  job_t          job,
  input  logic          px_ready,
  output logic          busy,
  output logic          px_valid,
  output logic [AW-1:0] px_addr
);
  localparam int EW = CW + 3;
  localparam logic [CW:0] WL = (CW+1)'(FB_W);
  localparam logic [CW:0] HL = (CW+1)'(FB_H);

  // setup, evaluated from the job presented with go
  coord_t dx, dy, dmaj, dmin, ma0, ma1, mi0, mi1;
  logic   swp, flip;
  logic signed [EW-1:0] h0, d0, e0;

  always_comb begin
    dx   = (job.x1 >= job.x0) ? job.x1 - job.x0 : job.x0 - job.x1;
    dy   = (job.y1 >= job.y0) ? job.y1 - job.y0 : job.y0 - job.y1;
    swp  = dy > dx;
    dmaj = swp ? dy : dx;
    dmin = swp ? dx : dy;
    ma0  = swp ? job.y0 : job.x0;
    ma1  = swp ? job.y1 : job.x1;
    mi0  = swp ? job.x0 : job.y0;
    mi1  = swp ? job.x1 : job.y1;
    flip = ma0 > ma1;
    h0   = $signed({2'b00, dmin, 1'b0});
    d0   = h0 - $signed({2'b00, dmaj, 1'b0});
    e0   = h0 - $signed({3'b000, dmaj});
  end

  logic                 busy_q, busy_n, swp_q, swp_n, neg_q, neg_n, le_q, le_n;
  coord_t               a_q, a_n, ae_q, ae_n, b_q, b_n;
  logic signed [EW-1:0] e_q, e_n, h_q, h_n, d_q, d_n;
  logic [LW-1:0]        k_q, k_n, sk_q, sk_n, lim_q, lim_n;
  coord_t               px_x, px_y;
  logic                 in_buf, wr, adv, last;

  always_comb begin
    px_x   = swp_q ? b_q : a_q;
    px_y   = swp_q ? a_q : b_q;
    in_buf = ({1'b0, px_x} < WL) && ({1'b0, px_y} < HL);
    wr     = in_buf && (k_q >= sk_q);
    adv    = busy_q && (!wr || px_ready);
    last   = (a_q == ae_q) || (le_q && ((k_q + LW'(1)) >= lim_q));
    busy_n = busy_q; swp_n = swp_q; neg_n = neg_q; le_n = le_q;
    a_n = a_q; ae_n = ae_q; b_n = b_q; e_n = e_q; h_n = h_q; d_n = d_q;
    k_n = k_q; sk_n = sk_q; lim_n = lim_q;
    if (go && !busy_q) begin
      busy_n = 1'b1;
      swp_n  = swp;
      a_n    = flip ? ma1 : ma0;
      ae_n   = flip ? ma0 : ma1;
      b_n    = flip ? mi1 : mi0;
      neg_n  = flip ? (mi1 > mi0) : (mi0 > mi1);
      e_n = e0; h_n = h0; d_n = d0;
      k_n = '0; sk_n = job.skip; lim_n = job.lim; le_n = job.lim_en;
    end else if (adv) begin
      if (last) begin
        busy_n = 1'b0;
      end else begin
        a_n = a_q + CW'(1);
        k_n = k_q + LW'(1);
        if (e_q > 0) begin
          b_n = neg_q ? b_q - CW'(1) : b_q + CW'(1);
          e_n = e_q + d_q;
        end else begin
          e_n = e_q + h_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; swp_q <= 1'b0; neg_q <= 1'b0; le_q <= 1'b0;
      a_q <= '0; ae_q <= '0; b_q <= '0; e_q <= '0; h_q <= '0; d_q <= '0;
      k_q <= '0; sk_q <= '0; lim_q <= '0;
    end else begin
      busy_q <= busy_n; swp_q <= swp_n; neg_q <= neg_n; le_q <= le_n;
      a_q <= a_n; ae_q <= ae_n; b_q <= b_n; e_q <= e_n; h_q <= h_n; d_q <= d_n;
      k_q <= k_n; sk_q <= sk_n; lim_q <= lim_n;
    end
  end

  assign busy     = busy_q;
  assign px_valid = busy_q && wr;
  assign px_addr  = AW'(px_y) * AW'(FB_W) + AW'(px_x);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_addr)));
  a_r5_inbuf: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> ({1'b0, px_addr} < (AW+1)'(FB_W*FB_H)));
  a_r12_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);
endmodule

// File: rtl/lnd_rop.sv
module lnd_rop
  import lnd_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] color,
  input  logic [PIX_W-1:0] pmask,
  input  logic [3:0]       rop,
  output logic [PIX_W-1:0] keep,
  output logic [PIX_W-1:0] flip
);
  always_comb begin
    keep = '1;
    flip = '0;
    case (rop_e'(rop))
      ROP_CLR: keep = ~pmask;
      ROP_CPY: begin keep = ~pmask; flip = color & pmask; end
      ROP_XOR: flip = color & pmask;
      ROP_INV: flip = pmask;
      ROP_SET: begin keep = ~pmask; flip = pmask; end
      default: ;
    endcase
  end
endmodule

// File: rtl/line_raster.sv
module line_raster
  import lnd_pkg::*;
#(
  parameter int FB_W  = 1280,
  parameter int FB_H  = 1024,
  parameter int PIX_W = 8,
  localparam int AW   = $clog2(FB_W*FB_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic             busy,
  output logic             px_valid,
  input  logic             px_ready,
  output logic [AW-1:0]    px_addr,
  output logic [PIX_W-1:0] px_keep,
  output logic [PIX_W-1:0] px_flip
);
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic             go;
  job_t             job;
  logic [PIX_W-1:0] seg_col, pmask;
  logic [3:0]       rop;

  lnd_regs #(.FB_W(FB_W), .FB_H(FB_H), .PIX_W(PIX_W)) regs_i (
    .clk(clk), .rst_n(rst_i), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .busy(busy), .go(go), .job(job), .seg_col(seg_col), .pmask(pmask), .rop(rop));

  lnd_stepper #(.FB_W(FB_W), .FB_H(FB_H)) step_i (
    .clk(clk), .rst_n(rst_i), .go(go), .job(job), .px_ready(px_ready),
    .busy(busy), .px_valid(px_valid), .px_addr(px_addr));

  lnd_rop #(.PIX_W(PIX_W)) rop_i (
    .color(seg_col), .pmask(pmask), .rop(rop), .keep(px_keep), .flip(px_flip));

  // R7: planes outside the mask are never disturbed, whatever the code
  a_r7_planes: assert property (@(posedge clk) disable iff (!rst_i)
    px_valid |-> (((px_keep | pmask) == '1) && ((px_flip & ~pmask) == '0)));
endmodule

// File: tb/line_raster_tb_top.sv
module line_raster_tb_top;
  localparam int W = 64, H = 48, AW = $clog2(W*H);
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, cfg_we = 0, px_ready = 1;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic busy, px_valid;
  logic [AW-1:0] px_addr;
  logic [7:0] px_keep, px_flip;

  line_raster #(.FB_W(W), .FB_H(H), .PIX_W(8)) dut_i (.*);

  always #(TCLK/2) clk = ~clk;

  int total = 0, bad = 0;
  bit fin = 0, rdy_rand = 0;
  bit [31:0] got_q[$], exp_q[$];
  int sx, sy, ex, ey, rop, skipm;
  bit [7:0] fg, bg, pm;
  bit sel;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0d exp=%0d", req, act, exp); end
  endtask

  initial forever begin
    @(negedge clk);
    if (px_valid && px_ready) got_q.push_back((32'(px_addr) << 16) | 32'({px_keep, px_flip}));
  end
  initial forever begin
    @(posedge clk); #1;
    px_ready = rdy_rand ? ($urandom % 3 != 0) : 1'b1;
  end

  function automatic bit [15:0] rop_m(bit [7:0] c);
    case (rop)
      0:  return {~pm, 8'h00};
      3:  return {~pm, c & pm};
      6:  return {8'hff, c & pm};
      10: return {8'hff, pm};
      15: return {~pm, pm};
      default: return {8'hff, 8'h00};
    endcase
  endfunction

  function automatic bit rej();
    return (sx >= W && ex >= W) || (sy >= H && ey >= H);
  endfunction

  task automatic model(int skip, bit le, int lim, bit [7:0] c);
    int dx, dy, dmaj, dmin, a0, a1, b0, b1, e, inc, a, b, k, x, y, t;
    bit swp, last;
    dx = (ex > sx) ? ex - sx : sx - ex;
    dy = (ey > sy) ? ey - sy : sy - ey;
    swp = dy > dx;
    dmaj = swp ? dy : dx; dmin = swp ? dx : dy;
    a0 = swp ? sy : sx; a1 = swp ? ey : ex; b0 = swp ? sx : sy; b1 = swp ? ex : ey;
    if (a0 > a1) begin t = a0; a0 = a1; a1 = t; t = b0; b0 = b1; b1 = t; end
    inc = (b0 <= b1) ? 1 : -1;
    e = 2*dmin - dmaj; a = a0; b = b0; k = 0;
    do begin
      x = swp ? b : a; y = swp ? a : b;
      if (k >= skip && x < W && y < H) exp_q.push_back(((y*W + x) << 16) | 32'(rop_m(c)));
      last = (a == a1) || (le && k + 1 >= lim);
      if (e > 0) begin b += inc; e += 2*(dmin - dmaj); end else e += 2*dmin;
      a++; k++;
    end while (!last);
  endtask

  task automatic wr(int a, bit [31:0] d);
    cfg_addr = a[2:0]; cfg_wdata = d; cfg_we = 1;
    @(posedge clk); #1; cfg_we = 0;
  endtask
  task automatic set_pts(int x0, int y0, int x1, int y1);
    wr(0, {x0[15:0], y0[15:0]}); wr(1, {x1[15:0], y1[15:0]});
    sx = x0; sy = y0; ex = x1; ey = y1;
  endtask
  task automatic set_op(bit s, int r);
    wr(3, {20'd0, r[3:0], 6'd0, s, 1'b0}); sel = s; rop = r;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask
  task automatic cmp(string req);
    int n;
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    chk(got_q.size() == exp_q.size(), {req, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < n; i++)
      if (got_q[i] != exp_q[i]) begin
        chk(0, {req, " pixel"}, int'(got_q[i]), int'(exp_q[i]));
        break;
      end
    if (n > 0) chk(1, req, 0, 0);
    got_q.delete(); exp_q.delete();
  endtask
  task automatic do_line(bit upd, string req);
    if (!rej()) begin
      model(0, 0, 0, sel ? fg : bg);
      if (upd) begin sx = ex; sy = ey; end
    end
    wr(5, {31'd0, upd}); wait_idle(); cmp(req);
  endtask
  task automatic do_dstart(int p, string req);
    if (!rej()) model(0, 1, p, sel ? fg : bg);
    skipm = p;
    wr(6, {p[15:0], 16'd0}); wait_idle(); cmp(req);
  endtask
  task automatic do_dnext(int l, string req);
    if (!rej()) model(skipm, 1, skipm + l, sel ? fg : bg);
    skipm += l; sel = !sel;
    wr(7, {l[15:0], 16'd0}); wait_idle(); cmp(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      chk(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rops[6] = '{0, 3, 6, 10, 15, 5};
    void'($urandom(32'd2024));
    sx = 0; sy = 0; ex = 0; ey = 0; rop = 3; pm = 8'hff; fg = 0; bg = 0; sel = 0; skipm = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && px_valid == 0, "R1 reset", busy, 0);
    @(posedge clk); #1; rst_n = 1;
    repeat (4) @(posedge clk); #1;
    // R1: reset register values seen through a line from (0,0)
    do_line(0, "R1 defaults");
    // R2 / R4 / R6
    wr(2, {8'd0, 8'h21, 8'd0, 8'h5a}); fg = 8'h5a; bg = 8'h21;
    set_op(1, 3);
    set_pts(2, 3, 9, 5);    do_line(0, "R4 shallow R2");
    set_pts(10, 20, 7, 4);  do_line(0, "R4 steep reversed");
    set_pts(30, 10, 12, 18); do_line(0, "R4 shallow reversed minor down");
    set_pts(5, 5, 5, 5);    do_line(0, "R4 single point");
    // R3 rejection, start kept
    set_pts(70, 1, 64, 30); do_line(1, "R3 reject");
    wr(1, {16'd3, 16'd3}); ex = 3; ey = 3;
    do_line(0, "R3 start kept R5 clip x");
    set_pts(5, 40, 5, 55);  do_line(0, "R5 clip y");
    // R10
    set_pts(1, 1, 6, 2);    do_line(1, "R10 update");
    wr(1, {16'd6, 16'd10}); ex = 6; ey = 10;
    do_line(0, "R10 from moved start");
    // R6 background select
    set_op(0, 3); set_pts(0, 0, 4, 1); do_line(0, "R6 background");
    // R7 each raster code
    wr(4, 32'h3c); pm = 8'h3c;
    foreach (rops[i]) begin set_op(1, rops[i]); do_line(0, "R7 rop"); end
    wr(4, 32'hff); pm = 8'hff; set_op(1, 3);
    // R8 / R9 dashes
    set_pts(0, 2, 20, 9);
    do_dstart(3, "R8 dash start");
    do_dstart(0, "R8 zero length");
    do_dstart(2, "R8 dash start 2");
    do_dnext(3, "R9 next a");
    do_dnext(2, "R9 next b");
    do_dnext(30, "R9 past end");
    // R11 stalls
    rdy_rand = 1; set_pts(3, 40, 50, 2); do_line(0, "R11 stall"); rdy_rand = 0;
    // R12 write on the same edge as last acceptance
    set_op(1, 3); set_pts(0, 8, 3, 8);
    model(0, 0, 0, fg);
    cfg_addr = 5; cfg_wdata = 0; cfg_we = 1; @(posedge clk); #1; cfg_we = 0;
    repeat (3) @(posedge clk);
    #1; cfg_addr = 3; cfg_wdata = 32'h0000_0300; cfg_we = 1;
    @(posedge clk); #1; cfg_we = 0;
    chk(busy == 0, "R11 busy falls", busy, 0);
    wait_idle(); cmp("R12 same edge");
    do_line(0, "R12 op kept");
    // R12 start write mid-line dropped
    set_pts(0, 0, 40, 3);
    model(0, 0, 0, fg);
    wr(5, 0); wr(0, {16'd9, 16'd9});
    wait_idle(); cmp("R12 mid line");
    do_line(0, "R12 start kept");
    // random mix
    rdy_rand = 1;
    for (int it = 0; it < 40; it++) begin
      set_pts($urandom % 80, $urandom % 60, $urandom % 80, $urandom % 60);
      set_op($urandom % 2, rops[$urandom % 6]);
      pm = 8'($urandom); wr(4, {24'd0, pm});
      case ($urandom % 4)
        0, 1: do_line($urandom % 2, "R4 random");
        2:    do_dstart($urandom % 6, "R8 random");
        default: do_dnext($urandom % 5, "R9 random");
      endcase
    end
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule